// File: doc/BRIEF.md
# Matrix Keypad Scanner and Key-Event Queue

This block scans an 8x8 key (or sensor) matrix one row at a time, reads the column return lines, and turns closures into one-byte key events. The events go into an 8-deep first-in-first-out queue. The oldest event is always shown on `key_data`, and a one-cycle `rd_strobe` removes it. A status word reports the queue fill level and three sticky error flags. An interrupt line tells the host when there is something to collect.

The scanner spends `PRESCALE` clocks on each row. At the last clock of a row period it captures the return lines, then moves to the next row. A walker evaluates the captured row one column per clock, so at most one event is produced per clock. A full scan is all eight rows, ending when the row counter wraps from 7 back to 0.

`mode_sel` selects the behaviour:
- `00` is a single-key lockout keyboard.
- `01` is an N-key rollover keyboard.
- `1x` is a sensor matrix, which records every level change.

Debounce is measured in whole scans. The mode is expected to change only while reset is applied.

The column walker has two states:
- `SCAN_WAIT` moves to `SCAN_WALK` on each row sample.
- `SCAN_WALK` moves back to `SCAN_WAIT` after the last column.

The lockout tracker has two states:
- `LK_IDLE` moves to `LK_DEBOUNCE` on a new closure in lockout mode.
- `LK_DEBOUNCE` moves back to `LK_IDLE` when the candidate is accepted, when the candidate is found released, when any other key newly closes, or when lockout mode is left.

Top module: `kbd_scan_encoder`

## Requirements
- R1: `scan_row` holds each row index for exactly `PRESCALE` (16) clocks, then steps to the next row, and wraps from 7 to 0.
- R2: An event byte is laid out as follows. Bit 7 is the key level after the event (1 = closed). Bit 6 is 0. Bits 5:3 are the scan row. Bits 2:0 are the return column.
- R3: Events leave the queue in the order they entered it. `key_data` shows the oldest event. `rd_strobe` removes that event. `status[3:0]` is the number of stored events.
- R4: In lockout mode, a key that newly closes is entered once it is still closed at its sample two scans later, provided no other key newly closed in between.
- R5: In lockout mode, if a second key newly closes while a first key is being debounced, neither key is entered.
- R6: In either keyboard mode, a key released before its second following sample is not entered.
- R7: In rollover mode, every key held through its two-scan debounce is entered independently of other keys. Entries follow scan order (row, then column).
- R8: An event arriving while the queue holds 8 entries is dropped, and the overrun flag `status[4]` is set.
- R9: A `rd_strobe` on an empty queue sets the underrun flag `status[5]` and leaves the count at 0.
- R10: `clr_err` clears `status[6:4]`.
- R11: With `spec_err_en` high in rollover mode, two or more new closures within one scan set `status[6]`. In the other modes `spec_err_en` has no effect.
- R12: In keyboard modes, `irq` is high exactly while the queue is non-empty, and it falls on the read of the last entry.
- R13: In sensor mode, every change of a matrix point is queued with its new level. `irq` rises only at the end of a scan in which a change occurred or an entry remained unread. It falls when a read empties the queue.
- R14: During and right after reset, `scan_row` is 0, `status` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 lockout, 01 rollover, 1x sensor matrix |
| spec_err_en | input | 1 | Enables the multiple-closure error (rollover only) |
| ret_col | input | 8 | Column return lines of the driven row, 1 = closed |
| rd_strobe | input | 1 | Removes the oldest event |
| clr_err | input | 1 | Clears the error flags |
| scan_row | output | 3 | Index of the row being driven |
| key_data | output | 8 | Oldest queued event |
| status | output | 7 | {multi-closure, underrun, overrun, count[3:0]} |
| irq | output | 1 | Data pending |

## Verification
Within the clock after a row sample, a closed key is seen as a closure. Its event is queued two scans after that sample, which is 256 to 384 clocks after the press. The bench therefore presses keys right after the row counter returns to 0. It checks for "not yet queued" one scan after the press and for "queued" three scans plus 16 clocks after it. This keeps every check clear of the window in which the event can land. Queue and flag results are due one clock after a read or clear strobe, and the bench reads them at the next falling edge. The sensor-mode interrupt is due at the end of the scan, so the bench checks it once mid-scan, where it must still be low, and again after row 7 has been walked.

// File: rtl/kse_pkg.sv
`timescale 1ns/1ps
package kse_pkg;
    typedef enum logic {
        SCAN_WAIT,
        SCAN_WALK
    } walk_state_e;

    typedef enum logic {
        LK_IDLE,
        LK_DEBOUNCE
    } lock_state_e;

    localparam logic [1:0] MODE_LOCKOUT  = 2'b00;
    localparam logic [1:0] MODE_ROLLOVER = 2'b01;
endpackage

// File: rtl/kse_scanner.sv
`timescale 1ns/1ps
module kse_scanner #(
    parameter int ROWS     = 8,
    parameter int PRESCALE = 16,
    localparam int RW = $clog2(ROWS),
    localparam int PW = $clog2(PRESCALE)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [RW-1:0] row_idx,
    output logic          samp
);
    logic [PW-1:0] pre_q;

    // The last clock of each row period is the sample clock.
    assign samp = (pre_q == PW'(PRESCALE - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q   <= '0;
            row_idx <= '0;
        end else if (samp) begin
            pre_q   <= '0;
            row_idx <= (row_idx == RW'(ROWS - 1)) ? '0 : row_idx + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R1
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp |=> row_idx == (($past(row_idx) == RW'(ROWS - 1)) ? '0 : $past(row_idx) + 1'b1));
endmodule

// File: rtl/kse_fifo.sv
`timescale 1ns/1ps
module kse_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [DW-1:0]   push_data,
    input  logic            rd_strobe,
    input  logic            clr_err,
    output logic [DW-1:0]   head,
    output logic [CNTW-1:0] count,
    output logic            overrun,
    output logic            underrun
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          pop, accept, full, empty;

    assign full   = (count == CNTW'(DEPTH));
    assign empty  = (count == '0);
    assign pop    = rd_strobe && !empty;
    assign accept = push && (!full || pop);
    assign head   = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (accept) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= '0;
            rd_q     <= '0;
            count    <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (accept) wr_q <= wr_q + 1'b1;
            if (pop)    rd_q <= rd_q + 1'b1;
            count <= count + CNTW'(accept) - CNTW'(pop);
            if (push && !accept)      overrun <= 1'b1;
            else if (clr_err)         overrun <= 1'b0;
            if (rd_strobe && empty)   underrun <= 1'b1;
            else if (clr_err)         underrun <= 1'b0;
        end
    end

    // R8
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CNTW'(DEPTH) && !rd_strobe) |=> overrun);

    // R9
    unr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && count == '0 && !push) |=> (underrun && count == '0));

    // R3
    pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && count != '0 && !push) |=> count == $past(count) - 1'b1);
endmodule

// File: rtl/kse_keylogic.sv
`timescale 1ns/1ps
module kse_keylogic
    import kse_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int COLS = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int CW  = $clog2(COLS),
    localparam int KCW = RW + CW,
    localparam int NK  = ROWS * COLS,
    localparam int DW  = KCW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            spec_en,
    input  logic            clr_err,
    input  logic            samp,
    input  logic [RW-1:0]   row_idx,
    input  logic [COLS-1:0] ret_col,
    output logic            push,
    output logic [DW-1:0]   push_data,
    output logic            scan_end,
    output logic            scan_changed,
    output logic            multi_err
);
    walk_state_e     ev_st, ev_nx;
    lock_state_e     lk_st, lk_nx;
    logic [COLS-1:0] img_q;
    logic [RW-1:0]   erow_q;
    logic [CW-1:0]   col_q;
    logic [NK-1:0]   prev_q, pend_q, stage_q;
    logic [KCW-1:0]  cand_q, key_idx;
    logic            cand_stage_q, scan_new_q, scan_chg_q;
    logic            walk, cur_dn, was_dn, new_close, changed;
    logic            is_lock, is_roll, is_sens;

    assign is_lock = (mode == MODE_LOCKOUT);
    assign is_roll = (mode == MODE_ROLLOVER);
    assign is_sens = mode[1];

    assign walk      = (ev_st == SCAN_WALK);
    assign key_idx   = {erow_q, col_q};
    assign cur_dn    = img_q[col_q];
    assign was_dn    = prev_q[key_idx];
    assign new_close = walk && cur_dn && !was_dn;
    assign changed   = walk && (cur_dn != was_dn);
    assign scan_end  = walk && (col_q == CW'(COLS - 1)) && (erow_q == RW'(ROWS - 1));
    assign scan_changed = scan_chg_q || changed;

    // Column walker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) ev_st <= SCAN_WAIT;
        else        ev_st <= ev_nx;
    end

    always_comb begin
        ev_nx = ev_st;
        unique case (ev_st)
            SCAN_WAIT: if (samp) ev_nx = SCAN_WALK;
            SCAN_WALK: if (col_q == CW'(COLS - 1)) ev_nx = SCAN_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q  <= '0;
            erow_q <= '0;
            col_q  <= '0;
        end else if (ev_st == SCAN_WAIT && samp) begin
            img_q  <= ret_col;
            erow_q <= row_idx;
            col_q  <= '0;
        end else if (walk) begin
            col_q <= col_q + 1'b1;
        end
    end

    // Lockout tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) lk_st <= LK_IDLE;
        else        lk_st <= lk_nx;
    end

    always_comb begin
        lk_nx = lk_st;
        unique case (lk_st)
            LK_IDLE: if (is_lock && new_close) lk_nx = LK_DEBOUNCE;
            LK_DEBOUNCE: begin
                if (!is_lock) begin
                    lk_nx = LK_IDLE;
                end else if (walk) begin
                    if (key_idx == cand_q) begin
                        if (!cur_dn || cand_stage_q) lk_nx = LK_IDLE;
                    end else if (new_close) begin
                        lk_nx = LK_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q       <= '0;
            cand_stage_q <= 1'b0;
        end else if (lk_st == LK_IDLE && lk_nx == LK_DEBOUNCE) begin
            cand_q       <= key_idx;
            cand_stage_q <= 1'b0;
        end else if (lk_st == LK_DEBOUNCE && walk && key_idx == cand_q && cur_dn) begin
            cand_stage_q <= 1'b1;
        end
    end

    // Per-key history and rollover debounce
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            pend_q  <= '0;
            stage_q <= '0;
        end else if (walk) begin
            prev_q[key_idx] <= cur_dn;
            if (!is_roll) begin
                pend_q[key_idx] <= 1'b0;
            end else if (new_close) begin
                pend_q[key_idx]  <= 1'b1;
                stage_q[key_idx] <= 1'b0;
            end else if (pend_q[key_idx]) begin
                if (!cur_dn || stage_q[key_idx]) pend_q[key_idx] <= 1'b0;
                else                             stage_q[key_idx] <= 1'b1;
            end
        end
    end

    // Per-scan bookkeeping and the multiple-closure flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_new_q <= 1'b0;
            scan_chg_q <= 1'b0;
            multi_err  <= 1'b0;
        end else begin
            scan_new_q <= scan_end ? 1'b0 : (scan_new_q || new_close);
            scan_chg_q <= scan_end ? 1'b0 : (scan_chg_q || changed);
            if (spec_en && is_roll && new_close && scan_new_q) multi_err <= 1'b1;
            else if (clr_err)                                  multi_err <= 1'b0;
        end
    end

    // Event output
    always_comb begin
        push = 1'b0;
        if (walk) begin
            if (is_sens)
                push = changed;
            else if (is_roll)
                push = pend_q[key_idx] && stage_q[key_idx] && cur_dn;
            else
                push = (lk_st == LK_DEBOUNCE) && (key_idx == cand_q) && cand_stage_q && cur_dn;
        end
        push_data = {cur_dn, 1'b0, erow_q, col_q};
    end

    // R4
    lk_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_lock) |=> (lk_st == LK_IDLE));

    // R11
    multi_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(multi_err) |-> ($past(mode) == MODE_ROLLOVER && $past(spec_en)));
endmodule

// File: rtl/kbd_scan_encoder.sv
`timescale 1ns/1ps
module kbd_scan_encoder #(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int PRESCALE = 16,
    parameter int DEPTH    = 8
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic [1:0]                                         mode_sel,
    input  logic                                               spec_err_en,
    input  logic [COLS-1:0]                                    ret_col,
    input  logic                                               rd_strobe,
    input  logic                                               clr_err,
    output logic [$clog2(ROWS)-1:0]                            scan_row,
    output logic [$clog2(ROWS)+$clog2(COLS)+1:0]               key_data,
    output logic [$clog2(DEPTH+1)+2:0]                         status,
    output logic                                               irq
);
    localparam int RW   = $clog2(ROWS);
    localparam int CW   = $clog2(COLS);
    localparam int DW   = RW + CW + 2;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic            samp, push, scan_end, scan_changed, multi_err;
    logic            overrun, underrun, sirq_q;
    logic [DW-1:0]   push_data;
    logic [CNTW-1:0] count;

    kse_scanner #(.ROWS(ROWS), .PRESCALE(PRESCALE)) u_scan (
        .clk(clk), .rst_n(rst_n), .row_idx(scan_row), .samp(samp)
    );

    kse_keylogic #(.ROWS(ROWS), .COLS(COLS)) u_keys (
        .clk(clk), .rst_n(rst_n), .mode(mode_sel), .spec_en(spec_err_en),
        .clr_err(clr_err), .samp(samp), .row_idx(scan_row), .ret_col(ret_col),
        .push(push), .push_data(push_data), .scan_end(scan_end),
        .scan_changed(scan_changed), .multi_err(multi_err)
    );

    kse_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .rd_strobe(rd_strobe), .clr_err(clr_err), .head(key_data),
        .count(count), .overrun(overrun), .underrun(underrun)
    );

    // Sensor-mode interrupt: raised at scan end, dropped when emptied
    always_ff @(posedge clk) begin
        if (!rst_n)
            sirq_q <= 1'b0;
        else if (!mode_sel[1])
            sirq_q <= 1'b0;
        else if (scan_end && (scan_changed || count != '0))
            sirq_q <= 1'b1;
        else if (rd_strobe && count == CNTW'(1) && !push)
            sirq_q <= 1'b0;
    end

    assign irq    = mode_sel[1] ? sirq_q : (count != '0);
    assign status = {multi_err, underrun, overrun, count};

    // R13
    sirq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sirq_q) |-> $past(scan_end));
endmodule

// File: tb/kbd_scan_encoder_test.sv
`timescale 1ns/1ps
module kbd_scan_encoder_test;
    localparam int SCAN = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       spec_err_en = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       clr_err = 1'b0;
    logic [7:0] ret_col;
    logic [2:0] scan_row;
    logic [7:0] key_data;
    logic [6:0] status;
    logic       irq;
    logic [7:0] keys [8];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign ret_col = keys[scan_row];

    kbd_scan_encoder uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .spec_err_en(spec_err_en),
        .ret_col(ret_col), .rd_strobe(rd_strobe), .clr_err(clr_err),
        .scan_row(scan_row), .key_data(key_data), .status(status), .irq(irq)
    );

    // row, column, expected event byte
    localparam logic [13:0] VEC [6] = '{
        {3'd0, 3'd0, 8'h80},
        {3'd7, 3'd7, 8'hBF},
        {3'd2, 3'd5, 8'h95},
        {3'd5, 3'd2, 8'hAA},
        {3'd3, 3'd6, 8'h9E},
        {3'd6, 3'd1, 8'hB1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_keys();
        for (int r = 0; r < 8; r++) keys[r] = 8'h00;
    endtask

    task automatic do_reset(input logic [1:0] m, input logic se);
        @(negedge clk);
        rst_n = 1'b0;
        clear_keys();
        mode_sel = m;
        spec_err_en = se;
        tick(4);
        rst_n = 1'b1;
    endtask

    task automatic sync_row0();
        @(negedge clk);
        while (scan_row != 3'd7) @(negedge clk);
        while (scan_row != 3'd0) @(negedge clk);
    endtask

    task automatic read_one();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        clear_keys();
        tick(3);
        // R14 reset state while held
        chk("R14 row in reset", scan_row, 0);
        chk("R14 status in reset", status, 0);
        chk("R14 irq in reset", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14 row after reset", scan_row, 0);
        chk("R14 status after reset", status, 0);

        // R1 row period
        begin
            int per;
            logic [2:0] r0;
            r0 = scan_row;
            while (scan_row == r0) @(negedge clk);
            r0 = scan_row;
            per = 0;
            while (scan_row == r0) begin
                @(negedge clk);
                per++;
            end
            chk("R1 row period", per, 16);
            chk("R1 row step", scan_row, r0 + 3'd1);
        end

        // Vector table, rollover mode: R2 R3 R7 R12
        do_reset(2'b01, 1'b0);
        for (int v = 0; v < 6; v++) begin
            logic [2:0] vr, vc;
            vr = VEC[v][13:11];
            vc = VEC[v][10:8];
            sync_row0();
            keys[vr][vc] = 1'b1;
            tick(SCAN + 8);
            chk("R7 not before debounce", status[3:0], 0);
            tick(2 * SCAN + 8);
            chk("R3 count one", status[3:0], 1);
            chk("R12 irq pending", irq, 1);
            chk("R2 code", key_data, VEC[v][7:0]);
            read_one();
            chk("R12 irq after last read", irq, 0);
            keys[vr][vc] = 1'b0;
            tick(SCAN + 8);
        end

        // R6 early release (lockout) ; R11 enable ignored in lockout
        do_reset(2'b00, 1'b1);
        sync_row0();
        keys[4][4] = 1'b1;
        tick(SCAN);
        keys[4][4] = 1'b0;
        tick(3 * SCAN);
        chk("R6 released key not entered", status[3:0], 0);

        // R4 lockout accept
        sync_row0();
        keys[1][3] = 1'b1;
        tick(3 * SCAN + 16);
        chk("R4 lockout accepted count", status[3:0], 1);
        chk("R4 lockout code", key_data, 8'h8B);
        read_one();
        keys[1][3] = 1'b0;
        tick(SCAN + 8);

        // R5 lockout two closures
        sync_row0();
        keys[1][2] = 1'b1;
        keys[4][6] = 1'b1;
        tick(3 * SCAN + 16);
        chk("R5 lockout both rejected", status[3:0], 0);
        chk("R11 no flag in lockout", status[6], 0);
        clear_keys();
        tick(SCAN + 8);

        // R7 ordering, R11 flag, R10 clear
        do_reset(2'b01, 1'b1);
        sync_row0();
        keys[3][1] = 1'b1;
        keys[1][4] = 1'b1;
        tick(3 * SCAN + 16);
        chk("R7 two entries", status[3:0], 2);
        chk("R7 first in scan order", key_data, 8'h8C);
        read_one();
        chk("R7 second in scan order", key_data, 8'h99);
        chk("R11 multi closure flag", status[6], 1);
        pulse_clr();
        chk("R10 multi flag cleared", status[6], 0);
        read_one();
        clear_keys();
        tick(SCAN + 8);

        // R8 overrun, R3 order, R9 underrun, R10 clear
        do_reset(2'b01, 1'b0);
        sync_row0();
        keys[0] = 8'hFF;
        keys[1][0] = 1'b1;
        tick(3 * SCAN + 16);
        chk("R8 queue full", status[3:0], 8);
        chk("R8 overrun flag", status[4], 1);
        chk("R11 flag off when disabled", status[6], 0);
        for (int i = 0; i < 8; i++) begin
            chk("R3 read order", key_data, 8'h80 + i);
            read_one();
        end
        chk("R3 drained", status[3:0], 0);
        read_one();
        chk("R9 underrun flag", status[5], 1);
        chk("R9 count stays zero", status[3:0], 0);
        pulse_clr();
        chk("R10 errors cleared", status[5:4], 0);
        clear_keys();
        tick(SCAN + 8);

        // R13 sensor mode
        do_reset(2'b10, 1'b0);
        sync_row0();
        keys[2][5] = 1'b1;
        tick(80);
        chk("R13 change queued", status[3:0], 1);
        chk("R13 irq waits for scan end", irq, 0);
        tick(70);
        chk("R13 irq at scan end", irq, 1);
        chk("R13 closure code", key_data, 8'h95);
        read_one();
        chk("R13 irq falls on empty", irq, 0);
        keys[2][5] = 1'b0;
        tick(2 * SCAN);
        chk("R13 release queued", status[3:0], 1);
        chk("R13 release code", key_data, 8'h15);
        chk("R13 irq for release", irq, 1);
        read_one();
        chk("R13 irq cleared again", irq, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule